// File: doc/BRIEF.md
# Flash Maintenance Sequencer

This block sits on the host side of a data-converter chip and carries out maintenance work on that chip's on-board flash through a plain register read/write bus. The user side takes one request at a time. A request is one of five operations: erase the whole array, erase one page, program one word, fetch one word, or load the coefficient RAM from flash. The block turns each request into its fixed series of register accesses. It waits on the target's busy flag or on a timed interval, and reports the end of the request with a one-cycle completion pulse, a result word and two error flags.

Every request starts by polling the target's mode register until it reports idle. Erase requests then wait for a fixed number of milliseconds, counted in clock cycles from a clock-frequency parameter. Program, fetch and load requests instead poll the busy flag again. Every poll loop is bounded, and a poll that never clears ends the request with a timeout error. While the converter is running, requests are refused.

Top module: `fmaint_seq`

## Requirements
- R1: Every accepted request first reads register 18h, repeating until bit 0 of the returned word is 0; only bit 0 is examined. No write is issued before that read returns 0.
- R2: Operation code 0 (array erase) writes 0000h to register 19h and then 0060h to register 18h. Operation code 1 (page erase) writes {cmd_addr[15:8], 00h} to 19h and then 0040h to 18h. Here cmd_addr[15:8] is the page and cmd_addr[7:0] the word.
- R3: Operation code 2 (program) writes cmd_addr to 19h, then cmd_wdata to 1Ah, then 0020h to 18h.
- R4: Operation code 3 (fetch) writes cmd_addr to 19h and 0080h to 18h. It then polls as in R7, then reads 1Bh, and presents that word on rd_data from the done cycle until the next accepted request.
- R5: Operation code 4 (load coefficients) writes only 00A0h to 18h, then polls as in R7.
- R6: After the command write of an erase, the block waits CLK_HZ/1000*200 cycles (array) or CLK_HZ/1000*20 cycles (page) with no bus traffic before done. done comes no earlier than that count and at most four cycles later.
- R7: Program, fetch and load re-read 18h after the command until bit 0 is 0 before finishing.
- R8: If POLL_MAX consecutive reads of 18h within one poll loop return bit 0 = 1, the request ends with done and err_tmo = 1, and no further access is issued. err_tmo and err_rej are never both 1.
- R9: A request seen while conv_run is 1, or with an operation code of 5 to 7, is refused. The next cycle shows done = 1 with err_rej = 1, busy stays 0, and no bus access is made.
- R10: busy rises the cycle after a request is accepted and falls in the same cycle that done is 1. Requests presented while busy is 1 are ignored.
- R11: reg_req stays high, with reg_we, reg_addr and reg_wdata stable, until reg_ack is sampled high. Only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request strobe, taken when busy is 0 |
| cmd_op | input | 3 | Operation code: 0 array erase, 1 page erase, 2 program, 3 fetch, 4 load coefficients |
| cmd_addr | input | 16 | Flash address: [15:8] page, [7:0] word |
| cmd_wdata | input | 16 | Word to program |
| conv_run | input | 1 | Converter running; refuses requests while high |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_tmo | output | 1 | Poll loop exhausted (valid with done, held) |
| err_rej | output | 1 | Request refused (valid with done, held) |
| rd_data | output | 16 | Word returned by a fetch |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 8 | Target register address |
| reg_wdata | output | 16 | Target register write data |
| reg_ack | input | 1 | Access complete, sampled on the clock edge |
| reg_rdata | input | 16 | Read data, valid with reg_ack |

## Verification
The bench pairs a behavioural model of the target with the exact access list each operation should produce. A wrong recipe, wrong page masking or a skipped pre-poll shows up as a mismatched access list. Poll loops are driven both to an immediate idle and to never-ending busy: a design with an off-by-one bound issues one read too many or too few, and one that ignores the bound hangs. Erase waits are timed from the command write to done, so a wrong cycle count shows up at once. Requests made while converting, with an illegal code, or while busy are checked for silent refusal, and a read after erasing confirms the target actually saw the commands.

// File: rtl/fmaint_pkg.sv
package fmaint_pkg;

    localparam int AW = 8;
    localparam int DW = 16;

    localparam logic [AW-1:0] RA_MODE = 8'h18;
    localparam logic [AW-1:0] RA_ADDR = 8'h19;
    localparam logic [AW-1:0] RA_DIN  = 8'h1A;
    localparam logic [AW-1:0] RA_DOUT = 8'h1B;

    typedef enum logic [2:0] {
        OP_MASS  = 3'd0,
        OP_PAGE  = 3'd1,
        OP_WRITE = 3'd2,
        OP_READ  = 3'd3,
        OP_COPY  = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PRE, ST_ADDR, ST_DATA, ST_CMD, ST_WAIT, ST_POST, ST_FETCH
    } st_e;

    // What a request needs beyond the common pre-poll and command write
    typedef struct packed {
        logic       set_addr;
        logic       load_data;
        logic       fixed_wait;
        logic       fetch;
        logic [7:0] code;
    } recipe_t;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } acc_t;

    function automatic logic op_legal(logic [2:0] raw);
        return raw <= 3'd4;
    endfunction

    function automatic recipe_t recipe_of(op_e op);
        recipe_t r;
        case (op)
            OP_MASS:  r = '{set_addr: 1'b1, load_data: 1'b0, fixed_wait: 1'b1, fetch: 1'b0, code: 8'h60};
            OP_PAGE:  r = '{set_addr: 1'b1, load_data: 1'b0, fixed_wait: 1'b1, fetch: 1'b0, code: 8'h40};
            OP_WRITE: r = '{set_addr: 1'b1, load_data: 1'b1, fixed_wait: 1'b0, fetch: 1'b0, code: 8'h20};
            OP_READ:  r = '{set_addr: 1'b1, load_data: 1'b0, fixed_wait: 1'b0, fetch: 1'b1, code: 8'h80};
            default:  r = '{set_addr: 1'b0, load_data: 1'b0, fixed_wait: 1'b0, fetch: 1'b0, code: 8'hA0};
        endcase
        return r;
    endfunction

    function automatic logic [DW-1:0] addr_for(op_e op, logic [DW-1:0] a);
        case (op)
            OP_MASS: return '0;
            OP_PAGE: return {a[15:8], 8'h00};
            default: return a;
        endcase
    endfunction

endpackage

// File: rtl/fmaint_bus.sv
module fmaint_bus
    import fmaint_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  acc_t          acc_in,
    output logic          reg_req,
    output logic          reg_we,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    input  logic          reg_ack,
    input  logic [DW-1:0] reg_rdata,
    output logic          fin,
    output logic [DW-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_req   <= 1'b0;
            reg_we    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            fin       <= 1'b0;
            rdata     <= '0;
        end else begin
            fin <= 1'b0;
            if (reg_req && reg_ack) begin
                reg_req <= 1'b0;
                fin     <= 1'b1;
                rdata   <= reg_rdata;
            end else if (start && !reg_req) begin
                reg_req   <= 1'b1;
                reg_we    <= acc_in.we;
                reg_addr  <= acc_in.addr;
                reg_wdata <= acc_in.data;
            end
        end
    end

endmodule

// File: rtl/fmaint_timer.sv
module fmaint_timer #(
    parameter int unsigned LEN_A = 200,
    parameter int unsigned LEN_B = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic sel_a,
    output logic expire
);

    localparam int unsigned MAXL = (LEN_A > LEN_B) ? LEN_A : LEN_B;
    localparam int TW = $clog2(MAXL + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= sel_a ? TW'(LEN_A) : TW'(LEN_B);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // The last counted cycle: the loaded length spans exactly LEN cycles
    assign expire = (cnt == TW'(1));

endmodule

// File: rtl/fmaint_ctrl.sv
module fmaint_ctrl
    import fmaint_pkg::*;
#(
    parameter int unsigned POLL_MAX = 4096
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [DW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic          conv_run,
    output logic          busy,
    output logic          done,
    output logic          err_tmo,
    output logic          err_rej,
    output logic [DW-1:0] rd_data,
    output logic          start,
    output acc_t          acc,
    input  logic          fin,
    input  logic [DW-1:0] rdata,
    output logic          tmr_load,
    output logic          tmr_sel_a,
    input  logic          tmr_exp
);

    localparam int PW = $clog2(POLL_MAX + 1);

    st_e           st;
    op_e           op_q;
    logic [DW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [PW-1:0] polls;
    logic          inflight;
    logic          is_acc;
    logic          poll_last;
    recipe_t       rcp;

    assign rcp       = recipe_of(op_q);
    assign tmr_sel_a = (op_q == OP_MASS);
    assign poll_last = (polls == PW'(POLL_MAX - 1));
    assign is_acc    = (st == ST_PRE) || (st == ST_ADDR) || (st == ST_DATA) ||
                       (st == ST_CMD) || (st == ST_POST) || (st == ST_FETCH);

    always_comb begin
        acc      = '0;
        tmr_load = 1'b0;
        case (st)
            ST_PRE, ST_POST: acc = '{we: 1'b0, addr: RA_MODE, data: '0};
            ST_ADDR:         acc = '{we: 1'b1, addr: RA_ADDR, data: addr_for(op_q, addr_q)};
            ST_DATA:         acc = '{we: 1'b1, addr: RA_DIN,  data: wdata_q};
            ST_CMD: begin
                acc      = '{we: 1'b1, addr: RA_MODE, data: {8'h00, rcp.code}};
                tmr_load = fin && rcp.fixed_wait;
            end
            ST_FETCH:        acc = '{we: 1'b0, addr: RA_DOUT, data: '0};
            default:         acc = '0;
        endcase
        start = is_acc && !inflight;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            op_q     <= OP_MASS;
            addr_q   <= '0;
            wdata_q  <= '0;
            polls    <= '0;
            inflight <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            err_tmo  <= 1'b0;
            err_rej  <= 1'b0;
            rd_data  <= '0;
        end else begin
            done <= 1'b0;
            if (start) inflight <= 1'b1;
            if (fin)   inflight <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        if (conv_run || !op_legal(cmd_op)) begin
                            done    <= 1'b1;
                            err_rej <= 1'b1;
                            err_tmo <= 1'b0;
                        end else begin
                            op_q    <= op_e'(cmd_op);
                            addr_q  <= cmd_addr;
                            wdata_q <= cmd_wdata;
                            polls   <= '0;
                            busy    <= 1'b1;
                            err_rej <= 1'b0;
                            err_tmo <= 1'b0;
                            st      <= ST_PRE;
                        end
                    end
                end
                ST_PRE, ST_POST: begin
                    if (fin) begin
                        if (!rdata[0]) begin
                            polls <= '0;
                            if (st == ST_PRE) begin
                                st <= rcp.set_addr ? ST_ADDR : ST_CMD;
                            end else if (rcp.fetch) begin
                                st <= ST_FETCH;
                            end else begin
                                st   <= ST_IDLE;
                                busy <= 1'b0;
                                done <= 1'b1;
                            end
                        end else if (poll_last) begin
                            err_tmo <= 1'b1;
                            st      <= ST_IDLE;
                            busy    <= 1'b0;
                            done    <= 1'b1;
                        end else begin
                            polls <= polls + 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    if (fin) st <= rcp.load_data ? ST_DATA : ST_CMD;
                end
                ST_DATA: begin
                    if (fin) st <= ST_CMD;
                end
                ST_CMD: begin
                    if (fin) begin
                        polls <= '0;
                        st    <= rcp.fixed_wait ? ST_WAIT : ST_POST;
                    end
                end
                ST_WAIT: begin
                    if (tmr_exp) begin
                        st   <= ST_IDLE;
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
                ST_FETCH: begin
                    if (fin) begin
                        rd_data <= rdata;
                        st      <= ST_IDLE;
                        busy    <= 1'b0;
                        done    <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fmaint_seq.sv
module fmaint_seq
    import fmaint_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 20_000_000,
    parameter int unsigned MASS_MS  = 200,
    parameter int unsigned PAGE_MS  = 20,
    parameter int unsigned POLL_MAX = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  logic [15:0] cmd_addr,
    input  logic [15:0] cmd_wdata,
    input  logic        conv_run,
    output logic        busy,
    output logic        done,
    output logic        err_tmo,
    output logic        err_rej,
    output logic [15:0] rd_data,
    output logic        reg_req,
    output logic        reg_we,
    output logic [7:0]  reg_addr,
    output logic [15:0] reg_wdata,
    input  logic        reg_ack,
    input  logic [15:0] reg_rdata
);

    localparam int unsigned MASS_CYC = CLK_HZ / 1000 * MASS_MS;
    localparam int unsigned PAGE_CYC = CLK_HZ / 1000 * PAGE_MS;

    logic          start;
    acc_t          acc;
    logic          fin;
    logic [DW-1:0] rdata;
    logic          tmr_load;
    logic          tmr_sel_a;
    logic          tmr_exp;

    fmaint_ctrl #(.POLL_MAX(POLL_MAX)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .conv_run  (conv_run),
        .busy      (busy),
        .done      (done),
        .err_tmo   (err_tmo),
        .err_rej   (err_rej),
        .rd_data   (rd_data),
        .start     (start),
        .acc       (acc),
        .fin       (fin),
        .rdata     (rdata),
        .tmr_load  (tmr_load),
        .tmr_sel_a (tmr_sel_a),
        .tmr_exp   (tmr_exp)
    );

    fmaint_bus u_bus (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .acc_in    (acc),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_ack   (reg_ack),
        .reg_rdata (reg_rdata),
        .fin       (fin),
        .rdata     (rdata)
    );

    fmaint_timer #(.LEN_A(MASS_CYC), .LEN_B(PAGE_CYC)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .sel_a  (tmr_sel_a),
        .expire (tmr_exp)
    );

endmodule

// File: rtl/fmaint_seq_chk.sv
module fmaint_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic        conv_run,
    input logic        busy,
    input logic        done,
    input logic        err_tmo,
    input logic        err_rej,
    input logic        reg_req,
    input logic        reg_we,
    input logic [7:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        reg_ack
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata))); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !reg_req); // R10

    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10

    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R10

    AST_REJ_WHILE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (done && err_rej) |-> !$past(busy)); // R9

    AST_INTERLOCK: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_valid && conv_run) |=> (!busy && done && err_rej)); // R9

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        done |-> !(err_tmo && err_rej)); // R8

    AST_WRITE_TARGETS: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_we) |-> (reg_addr == 8'h18 || reg_addr == 8'h19 || reg_addr == 8'h1A)); // R2

    AST_READ_TARGETS: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_we) |-> (reg_addr == 8'h18 || reg_addr == 8'h1B)); // R1

endmodule

bind fmaint_seq fmaint_seq_chk u_chk (.*);

// File: tb/fmaint_seq_tb.sv
module fmaint_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HZ         = 1000;
    localparam int PMAX       = 8;
    localparam int LAT        = 1;
    localparam int MASS_CYC   = HZ / 1000 * 200;
    localparam int PAGE_CYC   = HZ / 1000 * 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [15:0] cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        conv_run = 1'b0;
    logic        busy, done, err_tmo, err_rej;
    logic [15:0] rd_data;
    logic        reg_req, reg_we;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_ack = 1'b0;
    logic [15:0] reg_rdata = '0;

    fmaint_seq #(.CLK_HZ(HZ), .MASS_MS(200), .PAGE_MS(20), .POLL_MAX(PMAX)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .conv_run(conv_run),
        .busy(busy), .done(done), .err_tmo(err_tmo), .err_rej(err_rej),
        .rd_data(rd_data), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
        .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    int mon_fail = 0;
    int hs_viol = 0;

    // Behavioural target: register file plus flash array
    logic [15:0] mem [int];
    logic [15:0] fa = '0, fdin = '0, fdout = '0;
    int busy_left = 0;
    int post_busy = 0;
    int cmd_cyc = 0;
    int lat = 0;
    logic [24:0] log_q[$];
    logic [24:0] exp_q[$];

    function automatic logic [24:0] mk(logic we, logic [7:0] a, logic [15:0] d);
        return {we, a, d};
    endfunction

    task automatic serve();
        log_q.push_back(mk(reg_we, reg_addr, reg_we ? reg_wdata : 16'h0000));
        if (reg_we) begin
            case (reg_addr)
                8'h19: fa = reg_wdata;
                8'h1A: fdin = reg_wdata;
                8'h18: begin
                    cmd_cyc = cyc;
                    case (reg_wdata[7:0])
                        8'h60: mem.delete();
                        8'h40: for (int w = 0; w < 256; w++) begin
                            int k = int'({fa[15:8], w[7:0]});
                            if (mem.exists(k)) mem.delete(k);
                        end
                        8'h20: begin mem[int'(fa)] = fdin; busy_left = post_busy; end
                        8'h80: begin
                            fdout = mem.exists(int'(fa)) ? mem[int'(fa)] : 16'hFFFF;
                            busy_left = post_busy;
                        end
                        8'hA0: busy_left = post_busy;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end else begin
            case (reg_addr)
                8'h18: begin
                    if (busy_left > 0) begin busy_left--; reg_rdata = 16'h5A01; end
                    else reg_rdata = 16'h5A00;
                end
                8'h1B: reg_rdata = fdout;
                default: reg_rdata = 16'hDEAD;
            endcase
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            reg_ack = 1'b0;
            lat = 0;
        end else if (reg_ack) begin
            reg_ack = 1'b0;
        end else if (reg_req) begin
            if (lat >= LAT) begin
                lat = 0;
                serve();
                reg_ack = 1'b1;
            end else begin
                lat++;
            end
        end else if (lat > 0) begin
            hs_viol++; // request withdrawn before acknowledge
            lat = 0;
        end
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic exp_reads(logic [7:0] a, int k);
        for (int i = 0; i < k; i++) exp_q.push_back(mk(1'b0, a, 16'h0000));
    endtask

    task automatic exp_wr(logic [7:0] a, logic [15:0] d);
        exp_q.push_back(mk(1'b1, a, d));
    endtask

    task automatic cmp_seq(string req);
        bit ok = (log_q.size() == exp_q.size());
        int bad = -1;
        if (ok) begin
            for (int i = 0; i < log_q.size(); i++) begin
                if (log_q[i] != exp_q[i] && bad < 0) bad = i;
            end
        end
        if (bad >= 0) begin
            chk(1'b0, req, "access list entry", log_q[bad], exp_q[bad]);
        end else begin
            chk(ok, req, "access count", log_q.size(), exp_q.size());
        end
        exp_q.delete();
    endtask

    // Issue one request, wait for done, check busy each clock; returns cycles from command write to done
    task automatic run_op(logic [2:0] op, logic [15:0] a, logic [15:0] d, bit conv,
                          int pre, int post, bit exp_busy, int poke_at, output int dly);
        int n = 0;
        int extra = 0;
        int sz;
        @(negedge clk);
        busy_left = pre;
        post_busy = post;
        log_q.delete();
        cmd_cyc = cyc;
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; conv_run = conv;
        @(negedge clk);
        cmd_valid = 1'b0; conv_run = 1'b0;
        while (!done && n < 5000) begin
            if (busy != exp_busy) mon_fail++;
            @(negedge clk);
            n++;
            cmd_valid = 1'b0;
            if (n == poke_at) begin
                cmd_valid = 1'b1; cmd_op = 3'd4;
            end
        end
        cmd_valid = 1'b0;
        chk(done == 1'b1, "R10", "done seen", done, 1);
        if (busy) mon_fail++;
        dly = cyc - cmd_cyc;
        sz = log_q.size();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk(extra == 0 && log_q.size() == sz, "R10", "quiet after done", extra, 0);
    endtask

    int dly;

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !reg_req && !err_tmo && !err_rej, "R10", "reset state",
            {busy, done, reg_req, err_tmo, err_rej}, 0);

        // R1 R4 R7: fetch of an erased word with busy before and after
        run_op(3'd3, 16'h0305, 16'h0, 1'b0, 2, 3, 1'b1, -1, dly);
        exp_reads(8'h18, 3); exp_wr(8'h19, 16'h0305); exp_wr(8'h18, 16'h0080);
        exp_reads(8'h18, 4); exp_reads(8'h1B, 1);
        cmp_seq("R1 R4 R7 fetch");
        chk(rd_data == 16'hFFFF, "R4", "erased word", rd_data, 16'hFFFF);
        chk(!err_tmo && !err_rej, "R8", "no error on fetch", {err_tmo, err_rej}, 0);

        // R3: program
        run_op(3'd2, 16'h0305, 16'h1234, 1'b0, 0, 5, 1'b1, -1, dly);
        exp_reads(8'h18, 1); exp_wr(8'h19, 16'h0305); exp_wr(8'h1A, 16'h1234);
        exp_wr(8'h18, 16'h0020); exp_reads(8'h18, 6);
        cmp_seq("R3 program");

        run_op(3'd3, 16'h0305, 16'h0, 1'b0, 0, 0, 1'b1, -1, dly);
        exp_reads(8'h18, 1); exp_wr(8'h19, 16'h0305); exp_wr(8'h18, 16'h0080);
        exp_reads(8'h18, 1); exp_reads(8'h1B, 1);
        cmp_seq("R4 fetch no busy");
        chk(rd_data == 16'h1234, "R4", "programmed word", rd_data, 16'h1234);

        run_op(3'd2, 16'h0410, 16'hABCD, 1'b0, 1, 2, 1'b1, -1, dly);
        exp_reads(8'h18, 2); exp_wr(8'h19, 16'h0410); exp_wr(8'h1A, 16'hABCD);
        exp_wr(8'h18, 16'h0020); exp_reads(8'h18, 3);
        cmp_seq("R3 program page 4");

        // R2 R6: page erase masks the word field and waits
        run_op(3'd1, 16'h0377, 16'h0, 1'b0, 1, 0, 1'b1, -1, dly);
        exp_reads(8'h18, 2); exp_wr(8'h19, 16'h0300); exp_wr(8'h18, 16'h0040);
        cmp_seq("R2 page erase");
        chk(dly >= PAGE_CYC && dly <= PAGE_CYC + 4, "R6", "page wait cycles", dly, PAGE_CYC + 2);

        run_op(3'd3, 16'h0305, 16'h0, 1'b0, 0, 0, 1'b1, -1, dly);
        chk(rd_data == 16'hFFFF, "R2", "word in erased page", rd_data, 16'hFFFF);
        run_op(3'd3, 16'h0410, 16'h0, 1'b0, 0, 0, 1'b1, -1, dly);
        chk(rd_data == 16'hABCD, "R2", "other page kept", rd_data, 16'hABCD);

        // R2 R6: array erase ignores cmd_addr
        run_op(3'd0, 16'h1234, 16'h0, 1'b0, 0, 0, 1'b1, -1, dly);
        exp_reads(8'h18, 1); exp_wr(8'h19, 16'h0000); exp_wr(8'h18, 16'h0060);
        cmp_seq("R2 array erase");
        chk(dly >= MASS_CYC && dly <= MASS_CYC + 4, "R6", "array wait cycles", dly, MASS_CYC + 2);
        run_op(3'd3, 16'h0410, 16'h0, 1'b0, 0, 0, 1'b1, -1, dly);
        chk(rd_data == 16'hFFFF, "R2", "array erased", rd_data, 16'hFFFF);

        // R5 R7: load coefficients
        run_op(3'd4, 16'h0, 16'h0, 1'b0, 0, 4, 1'b1, -1, dly);
        exp_reads(8'h18, 1); exp_wr(8'h18, 16'h00A0); exp_reads(8'h18, 5);
        cmp_seq("R5 R7 load");

        // R9: refusal while converting and for an illegal code
        run_op(3'd3, 16'h0001, 16'h0, 1'b1, 0, 0, 1'b0, -1, dly);
        cmp_seq("R9 conv_run refusal traffic");
        chk(err_rej && !err_tmo, "R9", "conv_run refusal flags", {err_rej, err_tmo}, 2'b10);
        run_op(3'd6, 16'h0001, 16'h0, 1'b0, 0, 0, 1'b0, -1, dly);
        cmp_seq("R9 illegal code traffic");
        chk(err_rej, "R9", "illegal code flag", err_rej, 1);

        // R8: post-command poll never clears
        run_op(3'd2, 16'h0001, 16'h5555, 1'b0, 0, 100, 1'b1, -1, dly);
        exp_reads(8'h18, 1); exp_wr(8'h19, 16'h0001); exp_wr(8'h1A, 16'h5555);
        exp_wr(8'h18, 16'h0020); exp_reads(8'h18, PMAX);
        cmp_seq("R8 post timeout");
        chk(err_tmo && !err_rej, "R8", "post timeout flags", {err_tmo, err_rej}, 2'b10);

        // R8: pre-poll never clears, nothing written
        run_op(3'd4, 16'h0, 16'h0, 1'b0, 100, 0, 1'b1, -1, dly);
        exp_reads(8'h18, PMAX);
        cmp_seq("R8 R1 pre timeout");
        chk(err_tmo, "R8", "pre timeout flag", err_tmo, 1);

        run_op(3'd3, 16'h0001, 16'h0, 1'b0, 0, 0, 1'b1, -1, dly);
        chk(rd_data == 16'h5555 && !err_tmo, "R4", "fetch after timeout", {err_tmo, rd_data}, 17'h05555);

        // R10: request during an erase is ignored
        run_op(3'd1, 16'h0500, 16'h0, 1'b0, 0, 0, 1'b1, 8, dly);
        exp_reads(8'h18, 1); exp_wr(8'h19, 16'h0500); exp_wr(8'h18, 16'h0040);
        cmp_seq("R10 ignored while busy");

        chk(mon_fail == 0, "R10", "busy monitor", mon_fail, 0);
        chk(hs_viol == 0, "R11", "handshake hold", hs_viol, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule